// File: doc/BRIEF.md
# Embedded Controller Host Responder

This block is the controller side of a two-port host mailbox for an embedded controller. The host sees two byte-wide ports. Writing to the status/command port issues a command, and reading it returns a status byte. The data port carries address bytes, value bytes and result bytes in both directions. The block serves a 256-byte register space held inside it.

Each byte the host writes is latched. The block then reports it as busy for a fixed, parameterised number of cycles before it acts on the byte. This lets host software see the busy flag and wait on it, as it would with a slow controller. A read transaction is a read command followed by an address byte, and the block answers with the register value in the data port. A write transaction is a write command, then an address byte, then a value byte.

Burst enable and burst disable change only a status bit. A local event input latches an event number and raises a pending flag, and a query command hands that number to the host.

Top module: `ecResponder`

## Requirements
- R1: The status byte is read with `hostSel`=0 and the data byte with `hostSel`=1. The status bits are: bit 0 output-full, bit 1 input-busy, bit 3 last-byte-was-command, bit 4 burst, bit 5 event pending. Bits 2, 6 and 7 read 0. After reset the status reads 0x00 and the data port reads 0x00.
- R2: An accepted write to the command port sets the input-busy and last-byte-was-command bits. An accepted write to the data port sets input-busy and clears last-byte-was-command.
- R3: Input-busy stays set for exactly `LATENCY` clock cycles after the write edge. The byte is acted on at the edge where input-busy clears.
- R4: Command 0x80 followed by an address byte places the addressed register in the data port. Output-full is set at the same edge at which input-busy clears.
- R5: Command 0x81 followed by an address byte and then a value byte stores the value at that address. The 256 registers read 0x00 after reset.
- R6: A host read of the data port (`hostRd` with `hostSel`=1) clears output-full. A host read of the status port changes nothing.
- R7: Command 0x82 sets the burst bit and returns 0x90 with output-full set. Command 0x83 clears the burst bit. When either is consumed, last-byte-was-command clears.
- R8: A pulse on `evtPost` latches `evtCode` and sets event pending. Command 0x84 returns the latched code, or 0x00 when none is pending, with output-full set, and clears event pending.
- R9: An unknown command code is consumed with no effect, and the status returns to 0x00. A data byte written while no command is in progress is consumed and ignored.
- R10: A host write made while input-busy is set is dropped.
- R11: A command byte abandons any incomplete read or write sequence and starts the new command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostSel | input | 1 | Port select: 0 status/command, 1 data |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWData | input | 8 | Byte written by the host |
| hostRData | output | 8 | Byte returned to the host for the selected port |
| evtPost | input | 1 | Raise an event to be queried |
| evtCode | input | 8 | Event number latched by `evtPost` |

## Verification
The bench counts, cycle by cycle, how long input-busy stays set. A design with an off-by-one busy counter would show `LATENCY`±1 cycles. A second byte written straight after a command must be dropped. If it were accepted, the command would be overwritten and the status would show the wrong last-byte-was-command state.

Other tests cover the following corner cases:
- A command issued halfway through a write sequence. A design that ignored the new command would store 0x80 as data.
- Repeated status-port reads while output-full is set. These must not clear it, and a design that decoded the read strobe without the port select would lose the result.
- Address boundaries at 0x00 and 0xFF, and event queries with and without a pending event.

// File: rtl/ecPkg.sv
package ecPkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_WR_ADDR,
    ST_WR_DATA
  } ecState_e;

  // strobes from control to datapath, valid for one cycle at consume time
  typedef struct packed {
    logic addrLoad;
    logic memWrite;
    logic outMem;
    logic outAck;
    logic outEvt;
    logic burstOn;
    logic burstOff;
  } ecStrobe_t;

  localparam logic [7:0] OP_READ      = 8'h80;
  localparam logic [7:0] OP_WRITE     = 8'h81;
  localparam logic [7:0] OP_BURST_ON  = 8'h82;
  localparam logic [7:0] OP_BURST_OFF = 8'h83;
  localparam logic [7:0] OP_QUERY     = 8'h84;
  localparam logic [7:0] BURST_ACK    = 8'h90;
endpackage

// File: rtl/ecControl.sv
module ecControl import ecPkg::*; #(
  parameter int LATENCY = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWr,
  input  logic [7:0] hostWData,
  output logic       ibfFlag,
  output logic       cmdFlag,
  output ecStrobe_t  strobe,
  output logic [7:0] heldByte
);
  localparam int CNT_W = $clog2(LATENCY + 1);

  logic [CNT_W-1:0] waitCnt;
  logic             heldIsCmd;
  ecState_e         state, stateNext;
  logic             acceptWr, consume, cmdDrop;

  assign acceptWr = hostWr && !ibfFlag;
  assign consume  = ibfFlag && (waitCnt == '0);

  always_comb begin
    strobe    = '0;
    stateNext = state;
    if (consume) begin
      if (heldIsCmd) begin
        stateNext = ST_IDLE;
        case (heldByte)
          OP_READ:      stateNext = ST_RD_ADDR;
          OP_WRITE:     stateNext = ST_WR_ADDR;
          OP_BURST_ON:  begin strobe.burstOn = 1'b1; strobe.outAck = 1'b1; end
          OP_BURST_OFF: strobe.burstOff = 1'b1;
          OP_QUERY:     strobe.outEvt = 1'b1;
          default:      ;
        endcase
      end else begin
        case (state)
          ST_RD_ADDR: begin strobe.outMem = 1'b1; stateNext = ST_IDLE; end
          ST_WR_ADDR: begin strobe.addrLoad = 1'b1; stateNext = ST_WR_DATA; end
          ST_WR_DATA: begin strobe.memWrite = 1'b1; stateNext = ST_IDLE; end
          default:    stateNext = ST_IDLE;
        endcase
      end
    end
  end

  assign cmdDrop = consume && heldIsCmd && (stateNext == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      ibfFlag   <= 1'b0;
      cmdFlag   <= 1'b0;
      heldIsCmd <= 1'b0;
      heldByte  <= '0;
      waitCnt   <= '0;
    end else if (acceptWr) begin
      heldByte  <= hostWData;
      heldIsCmd <= !hostSel;
      cmdFlag   <= !hostSel;
      ibfFlag   <= 1'b1;
      waitCnt   <= CNT_W'(LATENCY - 1);
    end else if (consume) begin
      ibfFlag <= 1'b0;
      state   <= stateNext;
      if (cmdDrop) cmdFlag <= 1'b0;
    end else if (waitCnt != '0) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end
endmodule

// File: rtl/ecDatapath.sv
module ecDatapath import ecPkg::*; #(
  parameter int ADDR_W = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  ecStrobe_t  strobe,
  input  logic [7:0] heldByte,
  input  logic       dataRd,
  input  logic       evtPost,
  input  logic [7:0] evtCode,
  output logic [7:0] outByte,
  output logic       obfFlag,
  output logic       burstFlag,
  output logic       sciFlag
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0]        regFile [DEPTH];
  logic [ADDR_W-1:0] addrReg;
  logic [7:0]        evtLatch;
  logic              produce;

  assign produce = strobe.outMem || strobe.outAck || strobe.outEvt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) regFile[i] <= '0;
      addrReg   <= '0;
      outByte   <= '0;
      obfFlag   <= 1'b0;
      burstFlag <= 1'b0;
      sciFlag   <= 1'b0;
      evtLatch  <= '0;
    end else begin
      if (strobe.addrLoad) addrReg <= heldByte[ADDR_W-1:0];
      if (strobe.memWrite) regFile[addrReg] <= heldByte;

      if (strobe.outMem)      outByte <= regFile[heldByte[ADDR_W-1:0]];
      else if (strobe.outAck) outByte <= BURST_ACK;
      else if (strobe.outEvt) outByte <= sciFlag ? evtLatch : 8'h00;

      if (produce)     obfFlag <= 1'b1;
      else if (dataRd) obfFlag <= 1'b0;

      if (strobe.burstOn)       burstFlag <= 1'b1;
      else if (strobe.burstOff) burstFlag <= 1'b0;

      if (evtPost) begin
        sciFlag  <= 1'b1;
        evtLatch <= evtCode;
      end else if (strobe.outEvt) begin
        sciFlag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecResponder.sv
module ecResponder import ecPkg::*; #(
  parameter int LATENCY = 4,
  parameter int ADDR_W  = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostRd,
  input  logic       hostWr,
  input  logic [7:0] hostWData,
  output logic [7:0] hostRData,
  input  logic       evtPost,
  input  logic [7:0] evtCode
);
  ecStrobe_t  strobe;
  logic [7:0] heldByte, outByte, statusByte;
  logic       ibfFlag, cmdFlag, obfFlag, burstFlag, sciFlag;

  ecControl #(.LATENCY(LATENCY)) control (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostWr(hostWr),
    .hostWData(hostWData), .ibfFlag(ibfFlag), .cmdFlag(cmdFlag),
    .strobe(strobe), .heldByte(heldByte)
  );

  ecDatapath #(.ADDR_W(ADDR_W)) datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .heldByte(heldByte),
    .dataRd(hostRd && hostSel), .evtPost(evtPost), .evtCode(evtCode),
    .outByte(outByte), .obfFlag(obfFlag), .burstFlag(burstFlag),
    .sciFlag(sciFlag)
  );

  assign statusByte = {2'b00, sciFlag, burstFlag, cmdFlag, 1'b0, ibfFlag, obfFlag};
  assign hostRData  = hostSel ? outByte : statusByte;
endmodule

// File: rtl/ecResponderChecker.sv
module ecResponderChecker #(
  parameter int LATENCY = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       hostSel,
  input logic       hostRd,
  input logic       hostWr,
  input logic [7:0] hostRData,
  input logic       ibfFlag,
  input logic       cmdFlag,
  input logic       obfFlag
);
  logic [15:0] busyCnt;

  always_ff @(posedge clk) begin
    if (!rstN)        busyCnt <= '0;
    else if (ibfFlag) busyCnt <= busyCnt + 1'b1;
    else              busyCnt <= '0;
  end

  assert_reserved_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hostSel |-> ((hostRData & 8'hC4) == 8'h00));

  assert_busy_from_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ibfFlag) |-> $past(hostWr));

  assert_busy_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ibfFlag) |-> (busyCnt == 16'(LATENCY)));

  assert_result_on_consume_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(obfFlag) |-> $fell(ibfFlag));

  assert_full_cleared_by_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(obfFlag) |-> $past(hostRd && hostSel));

  assert_busy_write_dropped_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdFlag) |-> $past(hostWr && !hostSel && !ibfFlag));
endmodule

bind ecResponder ecResponderChecker #(.LATENCY(LATENCY)) checker0 (
  .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostRd(hostRd), .hostWr(hostWr),
  .hostRData(hostRData), .ibfFlag(ibfFlag), .cmdFlag(cmdFlag), .obfFlag(obfFlag)
);

// File: tb/ecResponder_test.sv
module ecResponder_test;
  localparam int CLK_PERIOD = 10;
  localparam int LAT        = 4;
  // {address, value}
  localparam logic [15:0] VEC [8] = '{
    16'h005A, 16'hFFA5, 16'h013C, 16'h80C3,
    16'h7F01, 16'h42FE, 16'h1000, 16'hA077
  };

  logic       clk = 0;
  logic       rstN = 0;
  logic       hostSel = 0, hostRd = 0, hostWr = 0, evtPost = 0;
  logic [7:0] hostWData = 0, evtCode = 0;
  logic [7:0] hostRData;
  int         total = 0, bad = 0;
  logic       done = 0;

  ecResponder #(.LATENCY(LAT), .ADDR_W(8)) uut (
    .clk(clk), .rstN(rstN), .hostSel(hostSel), .hostRd(hostRd), .hostWr(hostWr),
    .hostWData(hostWData), .hostRData(hostRData), .evtPost(evtPost), .evtCode(evtCode)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic sel, input logic [7:0] b);
    @(negedge clk);
    hostSel = sel; hostWData = b; hostWr = 1;
    @(negedge clk);
    hostWr = 0;
  endtask

  task automatic peekStatus(output logic [7:0] v);
    hostSel = 0; hostRd = 0;
    #1 v = hostRData;
  endtask

  task automatic waitIdle();
    logic [7:0] s;
    for (int i = 0; i < 50; i++) begin
      peekStatus(s);
      if (!s[1]) return;
      @(negedge clk);
    end
    check("R3 busy never cleared", s, 8'h00);
  endtask

  task automatic readPort(input logic sel, output logic [7:0] v);
    @(negedge clk);
    hostSel = sel; hostRd = 1;
    #1 v = hostRData;
    @(negedge clk);
    hostRd = 0;
  endtask

  task automatic ecWrite(input logic [7:0] a, input logic [7:0] d);
    hostWrite(0, 8'h81); waitIdle();
    hostWrite(1, a);     waitIdle();
    hostWrite(1, d);     waitIdle();
  endtask

  task automatic ecRead(input logic [7:0] a, output logic [7:0] v);
    logic [7:0] s;
    hostWrite(0, 8'h80); waitIdle();
    hostWrite(1, a);     waitIdle();
    peekStatus(s);
    check("R4 output-full after read", s & 8'h01, 8'h01);
    readPort(1, v);
    peekStatus(s);
    check("R6 data read clears output-full", s & 8'h01, 8'h00);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, v;
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    peekStatus(s);
    check("R1 reset status", s, 8'h00);
    hostSel = 1; #1 check("R1 reset data", hostRData, 8'h00);

    // R5 register space clears at reset
    ecRead(8'h7E, v);
    check("R5 reset register value", v, 8'h00);

    // vector table: writes then read-backs (R4, R5)
    for (int i = 0; i < 8; i++) ecWrite(VEC[i][15:8], VEC[i][7:0]);
    for (int i = 0; i < 8; i++) begin
      ecRead(VEC[i][15:8], v);
      check("R5 stored value", v, VEC[i][7:0]);
    end

    // R2/R3 busy window length, flags on command write
    hostWrite(0, 8'h83);
    peekStatus(s);
    check("R2 command write flags", s, 8'h0A);
    cnt = 0;
    for (int i = 0; i < 50; i++) begin
      peekStatus(s);
      if (!s[1]) break;
      cnt++;
      @(negedge clk);
    end
    check("R3 busy cycles", 8'(cnt), 8'(LAT));
    check("R7 burst-off leaves status clear", s, 8'h00);

    // R7 burst enable, R6 status reads have no effect
    hostWrite(0, 8'h82); waitIdle();
    readPort(0, s);
    check("R6 status read one", s, 8'h11);
    readPort(0, s);
    check("R6 status read two", s, 8'h11);
    readPort(1, v);
    check("R7 burst ack", v, 8'h90);
    peekStatus(s);
    check("R7 burst bit held", s, 8'h10);
    hostWrite(0, 8'h83); waitIdle();
    peekStatus(s);
    check("R7 burst cleared", s, 8'h00);

    // R8 query with no event, then with one
    hostWrite(0, 8'h84); waitIdle();
    peekStatus(s);
    check("R8 query no event status", s, 8'h01);
    readPort(1, v);
    check("R8 query no event data", v, 8'h00);
    @(negedge clk); evtPost = 1; evtCode = 8'h2C;
    @(negedge clk); evtPost = 0;
    peekStatus(s);
    check("R8 event pending bit", s, 8'h20);
    hostWrite(0, 8'h84); waitIdle();
    peekStatus(s);
    check("R8 query clears pending", s, 8'h01);
    readPort(1, v);
    check("R8 query event code", v, 8'h2C);

    // R9 unknown command and stray data byte
    hostWrite(0, 8'h55); waitIdle();
    peekStatus(s);
    check("R9 unknown command status", s, 8'h00);
    hostWrite(1, 8'h33);
    peekStatus(s);
    check("R2 data write flags", s, 8'h02);
    waitIdle();
    peekStatus(s);
    check("R9 stray data status", s, 8'h00);

    // R10 write during busy is dropped
    hostWrite(0, 8'h81);
    hostWrite(1, 8'h77);
    waitIdle();
    peekStatus(s);
    check("R10 command survives busy write", s, 8'h08);
    hostWrite(1, 8'h40); waitIdle();
    hostWrite(1, 8'hAB); waitIdle();
    ecRead(8'h40, v);
    check("R10 write sequence intact", v, 8'hAB);

    // R11 new command abandons a partial write
    ecWrite(8'h05, 8'h11);
    hostWrite(0, 8'h81); waitIdle();
    hostWrite(1, 8'h05); waitIdle();
    hostWrite(0, 8'h80); waitIdle();
    hostWrite(1, 8'h05); waitIdle();
    readPort(1, v);
    check("R11 read after abandoned write", v, 8'h11);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule